// File: doc/BRIEF.md
# Local Clock Output Selector

This block drives four local clock pins. Each pin is set by a 4-bit select code held in one of two 8-bit control registers. The low three bits of the code pick one of eight timing sources. Source 0 is a constant zero. The others are the local frame pulse, the network reference pulse, the half-rate clock from the second PLL, and the 2.048, 4.096, 8.192 and 16.384 MHz clocks. The top bit of the code inverts the chosen source. This single rule yields static low, static high, inverted pulses and inverted clocks from one eight-entry table.

Software programs the block through a plain register port. A write strobe stores a byte at the addressed register on the rising clock edge. The read data follows the address combinationally. The timing sources are inputs; generating them lies outside this block. The outputs are combinational from the stored codes and the sources, so a changed code takes effect right after the write edge. The block has no streaming interface, so every pin is a plain control or data pin with no back-pressure.

Top module: `local_clk_select`

## Requirements
- R1: After reset both control registers hold 0x00, all four outputs are low, and reads of 0x05 and 0x06 return 0x00.
- R2: A write to address 0x05 sets the code of output 3 from data bits 7–4 and the code of output 2 from data bits 3–0.
- R3: A write to address 0x06 sets the code of output 1 from data bits 7–4 and the code of output 0 from data bits 3–0.
- R4: Code 0x0 holds its output low and code 0x8 holds it high, whatever the sources do.
- R5: Codes 0x1 to 0x7 pass, in this order, the frame pulse, the network reference pulse, the PLL half-rate clock, and the 2.048, 4.096, 8.192 and 16.384 MHz clocks.
- R6: Codes 0x9 to 0xF pass the same sources as codes 0x1 to 0x7, inverted.
- R7: A write to any address other than 0x05 or 0x06 changes no register and no output. A read of such an address returns 0x00.
- R8: A read of 0x05 or 0x06 returns the byte last written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| frame_pulse | input | 1 | Local frame pulse source |
| netref_pulse | input | 1 | Network reference pulse source |
| pll_half | input | 1 | Second PLL output divided by two |
| clk_2m | input | 1 | 2.048 MHz source |
| clk_4m | input | 1 | 4.096 MHz source |
| clk_8m | input | 1 | 8.192 MHz source |
| clk_16m | input | 1 | 16.384 MHz source |
| lclk_out | output | 4 | Local clock outputs, bit n is output n |

## Verification
A corrupt stored code shows up twice. The readback of its register returns the wrong byte as soon as the address is applied. The affected output follows the wrong source or the wrong polarity from the cycle after the write. The bench holds each source at a static level, chosen so that the right source and every wrong one give different output bits. A swapped nibble, a bad source index or a missing inversion therefore changes a sampled output bit in the first check after the write. A stray write that reached a register would turn an output high where low is expected.

// File: rtl/lclk_pkg.sv
package lclk_pkg;
  // Bits per select code and the position of its polarity flag
  localparam int SEL_W   = 4;
  localparam int POL_BIT = SEL_W - 1;
  // Number of base sources picked by the code bits below the flag
  localparam int NUM_SRC = 1 << POL_BIT;

  typedef logic [SEL_W-1:0] sel_code_t;
endpackage

// File: rtl/lclk_cfg_regs.sv
module lclk_cfg_regs #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_REGS  = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h05
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);
  localparam int FLAT_W = NUM_REGS * DATA_W;

  // Register k sits at BASE_ADDR+k. Register 0 fills the top byte of cfg_flat.
  logic [NUM_REGS-1:0] hit;

  generate
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      localparam int LSB = FLAT_W - (k + 1) * DATA_W;
      assign hit[k] = (addr == ADDR_W'(BASE_ADDR + k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cfg_flat[LSB +: DATA_W] <= '0;
        else if (wr_en && hit[k])
          cfg_flat[LSB +: DATA_W] <= wdata;
      end
    end
  endgenerate

  // Unmapped addresses read back as zero
  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (hit[k]) rdata = cfg_flat[FLAT_W - (k + 1) * DATA_W +: DATA_W];
  end
endmodule

// File: rtl/lclk_out_mux.sv
module lclk_out_mux
  import lclk_pkg::*;
(
  input  sel_code_t           code,
  input  logic [NUM_SRC-1:0]  srcs,
  output logic                out
);
  // The low bits pick a source and the top bit flips its polarity
  always_comb out = srcs[code[POL_BIT-1:0]] ^ code[POL_BIT];
endmodule

// File: rtl/local_clk_select.sv
module local_clk_select
  import lclk_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int NUM_OUT = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h05
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               frame_pulse,
  input  logic               netref_pulse,
  input  logic               pll_half,
  input  logic               clk_2m,
  input  logic               clk_4m,
  input  logic               clk_8m,
  input  logic               clk_16m,
  output logic [NUM_OUT-1:0] lclk_out
);
  localparam int CFG_W    = NUM_OUT * SEL_W;
  localparam int NUM_REGS = CFG_W / DATA_W;

  logic [CFG_W-1:0]   cfg_flat;
  logic [NUM_SRC-1:0] src_vec;

  // Base source 0 is a constant zero. With the flag set it gives a static high.
  assign src_vec = {clk_16m, clk_8m, clk_4m, clk_2m,
                    pll_half, netref_pulse, frame_pulse, 1'b0};

  lclk_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cfg_flat(cfg_flat)
  );

  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      lclk_out_mux u_mux (
        .code(cfg_flat[i*SEL_W +: SEL_W]),
        .srcs(src_vec),
        .out (lclk_out[i])
      );
    end
  endgenerate
endmodule

// File: rtl/lclk_select_chk.sv
module lclk_select_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic [15:0] cfg_flat,
  input logic        clk_2m,
  input logic [3:0]  lclk_out
);
  // R2
  hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h05) |=> (cfg_flat[15:8] == $past(wdata)));

  // R3
  lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h06) |=> (cfg_flat[7:0] == $past(wdata)));

  // R4
  static_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flat[15:12] == 4'h0) |-> !lclk_out[3]);

  // R4
  static_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flat[3:0] == 4'h8) |-> lclk_out[0]);

  // R6
  inv_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flat[11:8] == 4'hC) |-> (lclk_out[2] != clk_2m));

  // R7
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != 8'h05 && addr != 8'h06) |=> $stable(cfg_flat));

  // R7
  stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != 8'h05 && addr != 8'h06) |-> (rdata == 8'h00));

  // R8
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h05) |-> (rdata == cfg_flat[15:8]));
endmodule

bind local_clk_select lclk_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .cfg_flat(cfg_flat), .clk_2m(clk_2m), .lclk_out(lclk_out)
);

// File: tb/tb_local_clk_select.sv
module tb_local_clk_select;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [6:0] srcs = 7'h00; // {16m, 8m, 4m, 2m, pll, netref, frame}
  logic [3:0] lclk_out;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  local_clk_select dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .frame_pulse(srcs[0]), .netref_pulse(srcs[1]),
    .pll_half(srcs[2]), .clk_2m(srcs[3]), .clk_4m(srcs[4]),
    .clk_8m(srcs[5]), .clk_16m(srcs[6]), .lclk_out(lclk_out)
  );

  // {reg 0x05, reg 0x06, source levels, expected {o3,o2,o1,o0}}
  localparam int NV = 10;
  localparam logic [26:0] VEC [NV] = '{
    {8'h80, 8'h08, 7'b0000000, 4'b1001}, // R4
    {8'h80, 8'h08, 7'b1111111, 4'b1001}, // R4
    {8'h12, 8'h34, 7'b0000001, 4'b1000}, // R5
    {8'h12, 8'h34, 7'b0001010, 4'b0101}, // R5
    {8'h56, 8'h71, 7'b0110000, 4'b1100}, // R5
    {8'h56, 8'h71, 7'b1000101, 4'b0011}, // R5
    {8'h9A, 8'hBC, 7'b0000000, 4'b1111}, // R6
    {8'h9A, 8'hBC, 7'b0001011, 4'b0010}, // R6
    {8'hDE, 8'hF9, 7'b0010000, 4'b0111}, // R6
    {8'hDE, 8'hF9, 7'b1100001, 4'b1000}  // R6
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, int'(rdata), int'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outputs", int'(lclk_out), 0);
    rd_check("R1 read 0x05", 8'h05, 8'h00);
    rd_check("R1 read 0x06", 8'h06, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      wr(8'h05, VEC[v][26:19]);
      wr(8'h06, VEC[v][18:11]);
      srcs = VEC[v][10:4];
      #1;
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", v), int'(lclk_out), int'(VEC[v][3:0]));
      rd_check("R8 readback 0x05", 8'h05, VEC[v][26:19]);
      rd_check("R8 readback 0x06", 8'h06, VEC[v][18:11]);
    end

    // R2 and R3: a code on one output only, to catch swapped nibbles or registers
    srcs = 7'h00;
    wr(8'h05, 8'h08); wr(8'h06, 8'h00);
    #1 check("R2 low nibble drives output 2", int'(lclk_out), 4'b0100);
    wr(8'h05, 8'h00); wr(8'h06, 8'h80);
    #1 check("R3 high nibble drives output 1", int'(lclk_out), 4'b0010);

    // R7: stray writes of 0xFF would drive outputs high if they landed
    wr(8'h06, 8'h00);
    wr(8'h04, 8'hFF);
    wr(8'h07, 8'hFF);
    wr(8'h00, 8'hFF);
    #1 check("R7 stray writes leave outputs", int'(lclk_out), 0);
    rd_check("R7 read 0x04", 8'h04, 8'h00);
    rd_check("R7 read 0x07", 8'h07, 8'h00);
    rd_check("R7 0x05 kept", 8'h05, 8'h00);
    rd_check("R7 0x06 kept", 8'h06, 8'h00);

    // R1: reset in mid-run clears the stored codes
    wr(8'h05, 8'h88); wr(8'h06, 8'h88);
    #1 check("R4 all high before reset", int'(lclk_out), 4'hF);
    @(negedge clk) rst_n = 1'b0;
    #1 check("R1 outputs after reset", int'(lclk_out), 0);
    rd_check("R1 read 0x05 after reset", 8'h05, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule